// File: doc/BRIEF.md
# Single-Wire Bus ROM Search Step Engine

This block carries out one step of the binary ROM-search procedure on a single-wire bus. A search controller starts it with a preferred branch bit. The engine then asks an external slot generator for two read slots. The first read returns the bit that the responding devices hold at the current position. The second read returns the complement of that bit.

From those two bits the engine picks the branch direction. When the bus is still consistent, it asks for one write slot that sends the chosen direction back to the devices. It finishes with a one-cycle completion pulse and a 3-bit status word. The status packs the observed bit, the observed complement and the direction taken.

The slot generator is reached through a request/done handshake. The engine holds a request with its kind and write value until the generator pulses its done input. The loop across all 64 positions, the discrepancy bookkeeping and the ROM storage belong to the controller.

Top module: `owire_triplet`

## Requirements
- R1: While `rst_n` is low and after it is released, `busy`, `done` and `slot_req` are 0 and `status` is 3'b000, until a start is accepted.
- R2: `start` is accepted when `busy` is 0. In the next cycle `busy` and `slot_req` are 1, and `slot_write` is 0, which means a read slot.
- R3: Two read slots come first. The `slot_rbit` value returned with the first read's `slot_done` is stored in `status[0]`. The value returned with the second read's `slot_done` is stored in `status[1]`.
- R4: If both read values are 1, `status` becomes 3'b011 and no write slot is requested. This tells the controller that the search must restart.
- R5: If both read values are 0, the direction is the `pref_dir` value sampled in the cycle the start was accepted. `status[2]` equals that value, so the status is 3'b100 or 3'b000. Later changes of `pref_dir` have no effect.
- R6: If exactly one read value is 1, the direction equals the first read value whatever `pref_dir` is. The status is 3'b101 when the first value is 1 and 3'b010 when it is 0.
- R7: Unless R4 applies, exactly one write slot (`slot_write` = 1) follows the two reads. Its `slot_wbit` equals the direction stored in `status[2]`.
- R8: `done` is 1 for exactly one cycle: the cycle after the `slot_done` that ends the last slot. `slot_req` is 0 in that cycle. `status` changes only in a cycle where `done` is 1 and holds its value otherwise, including through the next start.
- R9: A `start` pulse while `busy` is 1 is ignored. The step in progress issues the same slots and status as without the pulse.
- R10: While a request is waiting for its `slot_done`, `slot_write` and `slot_wbit` stay unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin one search step (taken when idle) |
| pref_dir | input | 1 | Preferred branch bit, sampled with start |
| busy | output | 1 | Step in progress |
| done | output | 1 | One-cycle completion pulse |
| status | output | 3 | {direction, complement bit, id bit} |
| slot_req | output | 1 | Slot request to the slot generator |
| slot_write | output | 1 | 1 = write slot, 0 = read slot |
| slot_wbit | output | 1 | Bit sent by a write slot |
| slot_done | input | 1 | Slot generator finished the requested slot |
| slot_rbit | input | 1 | Sampled bus level, valid with slot_done of a read |

## Verification
The assertions assume the slot generator pulses `slot_done` only while `slot_req` is high. A done pulse ends the current request, and if `slot_req` is still high in the next cycle, a new request has begun. The bench's generator model follows this rule: it answers only a pending request after a chosen latency of zero to two cycles, and it drops `slot_done` after one cycle. Every combination of the two read values and the preferred bit is driven. The preferred bit is inverted right after acceptance to show that it is sampled at that point. A start during a busy step and a reset in the middle of a slot are also exercised.

// File: rtl/owt_pkg.sv
// Package: shared types of the ROM search step engine.
// Assumes: the status layout is fixed by the search protocol (bit0 id,
// bit1 complement, bit2 direction).
package owt_pkg;
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_RD_ID  = 3'd1,
        ST_RD_CMP = 3'd2,
        ST_WR     = 3'd3,
        ST_DONE   = 3'd4
    } owt_state_e;

    typedef struct packed {
        logic dir;
        logic cmp;
        logic id;
    } owt_status_t;

    localparam int OWT_STATUS_W = $bits(owt_status_t);
endpackage

// File: rtl/owt_decide.sv
// Module: branch decision of one search step.
// Purely combinational. Assumes id_bit and cmp_bit are the two read results,
// pref the preferred direction latched at start.
module owt_decide (
    input  logic id_bit,
    input  logic cmp_bit,
    input  logic pref,
    output logic dir,
    output logic restart
);
    // Pick the direction: invalid pair, forced by the single 1, or preferred.
    always_comb begin
        restart = id_bit & cmp_bit;
        if (restart)
            dir = 1'b0;
        else if (id_bit ^ cmp_bit)
            dir = id_bit;
        else
            dir = pref;
    end
endmodule

// File: rtl/owt_seq.sv
// Module: slot sequencer of one search step.
// Issues read, read and optionally write slots through a request/done
// handshake and records the status. Assumes slot_done arrives only while
// slot_req is high; a done pulse completes the current request.
module owt_seq
    import owt_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        pref_dir,
    input  logic        slot_done,
    input  logic        slot_rbit,
    input  logic        dec_dir,
    input  logic        dec_restart,
    output logic        pref_q,
    output logic        id_q,
    output logic        busy,
    output logic        done,
    output owt_status_t status_q,
    output logic        slot_req,
    output logic        slot_write,
    output logic        slot_wbit
);
    owt_state_e state_q, state_d;
    logic       dir_q;
    logic       cmp_q;

    // Next-state selection for the slot sequence.
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE:   if (start) state_d = ST_RD_ID;
            ST_RD_ID:  if (slot_done) state_d = ST_RD_CMP;
            ST_RD_CMP: if (slot_done) state_d = dec_restart ? ST_DONE : ST_WR;
            ST_WR:     if (slot_done) state_d = ST_DONE;
            ST_DONE:   state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Latch the preferred bit at accept and the read results at slot ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pref_q <= 1'b0;
            id_q   <= 1'b0;
            cmp_q  <= 1'b0;
            dir_q  <= 1'b0;
        end else begin
            if (state_q == ST_IDLE && start) pref_q <= pref_dir;
            if (state_q == ST_RD_ID && slot_done) id_q <= slot_rbit;
            if (state_q == ST_RD_CMP && slot_done) begin
                cmp_q <= slot_rbit;
                dir_q <= dec_dir;
            end
        end
    end

    // Status word, loaded only when the step completes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= '0;
        end else if (state_q == ST_RD_CMP && slot_done && dec_restart) begin
            status_q <= '{dir: 1'b0, cmp: 1'b1, id: 1'b1};
        end else if (state_q == ST_WR && slot_done) begin
            status_q <= '{dir: dir_q, cmp: cmp_q, id: id_q};
        end
    end

    // Handshake and status outputs decoded from the state.
    always_comb begin
        busy       = (state_q != ST_IDLE);
        done       = (state_q == ST_DONE);
        slot_req   = (state_q == ST_RD_ID) || (state_q == ST_RD_CMP) || (state_q == ST_WR);
        slot_write = (state_q == ST_WR);
        slot_wbit  = (state_q == ST_WR) ? dir_q : 1'b0;
    end
endmodule

// File: rtl/owire_triplet.sv
// Module: top of the ROM search step engine.
// Joins the sequencer and the decision logic. The decision sees the stored
// id bit and the live second read value so the direction is ready at the
// end of the second read.
module owire_triplet
    import owt_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic                    pref_dir,
    output logic                    busy,
    output logic                    done,
    output logic [OWT_STATUS_W-1:0] status,
    output logic                    slot_req,
    output logic                    slot_write,
    output logic                    slot_wbit,
    input  logic                    slot_done,
    input  logic                    slot_rbit
);
    logic        pref_q;
    logic        id_q;
    logic        dec_dir;
    logic        dec_restart;
    owt_status_t status_q;

    owt_decide u_decide (
        .id_bit  (id_q),
        .cmp_bit (slot_rbit),
        .pref    (pref_q),
        .dir     (dec_dir),
        .restart (dec_restart)
    );

    owt_seq u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .pref_dir    (pref_dir),
        .slot_done   (slot_done),
        .slot_rbit   (slot_rbit),
        .dec_dir     (dec_dir),
        .dec_restart (dec_restart),
        .pref_q      (pref_q),
        .id_q        (id_q),
        .busy        (busy),
        .done        (done),
        .status_q    (status_q),
        .slot_req    (slot_req),
        .slot_write  (slot_write),
        .slot_wbit   (slot_wbit)
    );

    // Present the packed status on the port.
    always_comb status = status_q;
endmodule

// File: rtl/owire_triplet_chk.sv
// Module: protocol checker for the ROM search step engine, bound to the top.
// Assumes slot_done only arrives while slot_req is high.
module owire_triplet_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic       busy,
    input logic       done,
    input logic [2:0] status,
    input logic       slot_req,
    input logic       slot_write,
    input logic       slot_wbit,
    input logic       slot_done
);
    assert_start_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (slot_req && !slot_write && busy));

    assert_restart_nodir_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && status[1:0] == 2'b11) |-> !status[2]);

    assert_forced_dir_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (status[0] ^ status[1])) |-> (status[2] == status[0]));

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_noreq_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !slot_req);

    assert_status_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(status));

    assert_req_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_req && $past(slot_req) && !$past(slot_done))
            |-> ($stable(slot_write) && $stable(slot_wbit)));
endmodule

bind owire_triplet owire_triplet_chk i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .busy       (busy),
    .done       (done),
    .status     (status),
    .slot_req   (slot_req),
    .slot_write (slot_write),
    .slot_wbit  (slot_wbit),
    .slot_done  (slot_done)
);

// File: tb/test_owire_triplet.sv
module test_owire_triplet;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       pref_dir = 1'b0;
    logic       busy, done, slot_req, slot_write, slot_wbit;
    logic [2:0] status;
    logic       slot_done = 1'b0;
    logic       slot_rbit = 1'b0;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #10 clk = ~clk;   // 50 MHz

    owire_triplet i_owire_triplet (
        .clk(clk), .rst_n(rst_n), .start(start), .pref_dir(pref_dir),
        .busy(busy), .done(done), .status(status),
        .slot_req(slot_req), .slot_write(slot_write), .slot_wbit(slot_wbit),
        .slot_done(slot_done), .slot_rbit(slot_rbit)
    );

    // Vector {id, cmp, pref, expected status[2:0], write expected}
    localparam logic [6:0] VECS [8] = '{
        7'b000_000_1, 7'b001_100_1, 7'b010_010_1, 7'b011_010_1,
        7'b100_101_1, 7'b101_101_1, 7'b110_011_0, 7'b111_011_0
    };

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Run one step with a slot generator model; poke=1 pulses start while busy.
    task automatic run_step(input logic id_b, input logic cmp_b, input logic pref_b,
                            input int lat, input bit poke,
                            output logic [2:0] st, output int nrd, output int nwr,
                            output logic wbit, output bit ok_timing);
        int  wait_cnt = 0;
        int  last_done_t = -10;
        bit  got = 0;
        logic [2:0] prev_st;
        prev_st = status;
        nrd = 0; nwr = 0; wbit = 1'b0; ok_timing = 1'b0; st = 3'b000;
        @(negedge clk); start = 1'b1; pref_dir = pref_b;
        @(negedge clk); start = 1'b0; pref_dir = ~pref_b;
        for (int t = 0; t < 100 && !got; t++) begin
            slot_done = 1'b0;
            start = (poke && t == 1);
            if (t == 0) begin
                check("R2 read request after accept", {slot_req, slot_write, busy}, 3'b101);
                check("R8 status held through next start", status, prev_st);
            end
            if (done) begin
                got = 1; st = status;
                ok_timing = (t == last_done_t + 1) && !slot_req;
            end else if (slot_req) begin
                if (wait_cnt == lat) begin
                    slot_done = 1'b1; wait_cnt = 0; last_done_t = t;
                    if (slot_write) begin nwr++; wbit = slot_wbit; end
                    else begin slot_rbit = (nrd == 0) ? id_b : cmp_b; nrd++; end
                end else wait_cnt++;
            end
            @(negedge clk);
        end
        start = 1'b0;
        slot_done = 1'b0;
        check("R8 done single cycle", done, 0);
        check("R8 status stable after done", status, st);
    endtask

    initial begin
        logic [2:0] st;
        int nrd, nwr;
        logic wbit;
        bit ok;
        repeat (3) @(negedge clk);
        check("R1 reset outputs", {busy, done, slot_req, status}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle after release", {busy, done, slot_req, status}, 0);

        for (int i = 0; i < 8; i++) begin
            logic [6:0] v;
            v = VECS[i];
            run_step(v[6], v[5], v[4], i % 3, 1'b0, st, nrd, nwr, wbit, ok);
            check("R3 R4 R5 R6 status", st, v[3:1]);
            check("R3 two reads", nrd, 2);
            check("R4 R7 write count", nwr, v[0] ? 1 : 0);
            if (v[0]) check("R7 write bit equals direction", wbit, v[3]);
            check("R8 done one cycle after last slot", ok, 1);
        end

        // R9: start while busy has no effect on the step
        run_step(1'b0, 1'b0, 1'b1, 2, 1'b1, st, nrd, nwr, wbit, ok);
        check("R9 status with start while busy", st, 3'b100);
        check("R9 slot count with start while busy", nrd + nwr, 3);
        check("R9 idle after step", busy, 0);

        // R5: preferred bit sampled at accept, later inversion ignored
        run_step(1'b0, 1'b0, 1'b0, 0, 1'b0, st, nrd, nwr, wbit, ok);
        check("R5 sampled preferred bit 0", st, 3'b000);
        check("R5 write bit 0", wbit, 0);

        // R1: reset in the middle of a slot returns to idle
        @(negedge clk); start = 1'b1; pref_dir = 1'b1;
        @(negedge clk); start = 1'b0;
        @(negedge clk);
        check("R2 request pending before reset", slot_req, 1);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 reset mid-step", {busy, done, slot_req, status}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle after mid-step reset", {busy, slot_req}, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            checks = checks + 1;
            errors = errors + 1;
            $display("FAIL R8 watchdog actual=%0d expected=%0d", cycles, 100000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule